// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block sits behind a CAN bit-level receiver and decides where each received frame goes. A frame arrives as one strobe carrying its identifier, its frame format (standard or extended), its data length code and eight data bytes. The block holds eight mailboxes. Each mailbox has a mode, an acceptance mask, a reference identifier, ready and ignored status flags, the stored length and data, and a family value. The block compares the masked identifier of the frame with every mailbox that is set up for reception. It picks one winner and stores the frame there.

A configuration port writes the mode, mask and identifier of any mailbox. An arm command re-opens a receive mailbox after its contents have been consumed. A combinational read port returns any field of any mailbox. A registered hit flag, with the index of the winning mailbox, reports each accepted frame one cycle after the strobe.

Top module: `can_rx_filter`

## Requirements
- R1: After reset, every field of every mailbox reads zero and `hit` is low.
- R2: Writing mode value 0 to a mailbox clears its mask, identifier, status, length, data and family fields.
- R3: A standard frame matches a mailbox when (frame ID AND mask) equals (mailbox ID AND mask) over identifier bits 28:18 only. The 11-bit standard ID is carried in `rx_id[28:18]`.
- R4: A mailbox expects extended frames only when bit 29 is set in both its mask and its identifier word. Such a mailbox compares all 29 bits. A mailbox matches only frames whose `rx_ext` equals this expectation.
- R5: Only mode 1 (receive) and mode 2 (receive with overwrite) take part in filtering. Mode 0 and modes 3 to 7 never accept a frame.
- R6: Among the matching mailboxes, the lowest-numbered one that is not ready wins. If every matching mailbox is ready, the lowest-numbered match wins.
- R7: Storing into a mailbox that is not ready sets ready (status bit 0) and puts the length code in status bits 7:4. Data bytes 0 to 3 (`rx_data[31:0]`, byte 0 in bits 7:0) go to the low word. Bytes 4 to 7 go to the high word, which reads zero when the length code is 4 or less.
- R8: When a frame wins a ready mailbox in mode 1, the ignored flag (status bit 1) is set and the stored length, data and family are kept.
- R9: When a frame wins a ready mailbox in mode 2, the ignored flag is set and the stored contents are replaced by the new frame.
- R10: An arm command on a mailbox in mode 1 or 2 clears its ready and ignored flags.
- R11: The family value of a stored frame is frame ID AND NOT mask. For a standard mailbox this is limited to bits 28:18, and all other bits read zero.
- R12: `hit` is high, and `hit_mb` holds the winning index, in the cycle after an accepted frame strobe. `hit` is low after a strobe that no mailbox accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mb | input | 3 | Mailbox addressed by the write |
| cfg_sel | input | 3 | Field select: 0 mode, 1 mask, 2 identifier |
| cfg_wdata | input | 32 | Write data (mode in bits 2:0; mask/ID in 28:0, extended flag in bit 29) |
| cmd_arm | input | 1 | Arm (re-open) command strobe |
| cmd_mb | input | 3 | Mailbox addressed by the arm command |
| rd_mb | input | 3 | Mailbox addressed by the read |
| rd_sel | input | 3 | Read select: 0 mode, 1 mask, 2 ID, 3 status, 4 low data, 5 high data, 6 family |
| rd_data | output | 32 | Combinational read data |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Frame identifier (standard ID in bits 28:18) |
| rx_ext | input | 1 | Frame uses the extended format |
| rx_dlc | input | 4 | Frame data length code |
| rx_data | input | 64 | Frame data, byte 0 in bits 7:0 |
| hit | output | 1 | A frame was accepted in the previous cycle |
| hit_mb | output | 3 | Index of the accepting mailbox |

## Verification
The bench first covers priority. Several mailboxes share one identifier, and frames are sent until all of them are full. A wrong priority encoder would fill the wrong mailbox, or would skip a free mailbox to overwrite a full one. The bench also sends standard frames to extended mailboxes, the reverse, and frames to mailboxes whose mask or identifier has only one of the two format bits set. A filter that checks the format bit loosely would accept these frames. It sends frames that hit ready mailboxes in both receive modes. A design that mixed up the two modes would keep data it should replace, or replace data it should keep. It also checks the family value and the zeroed high word on short frames, where a mask polarity error or a missing length gate shows up at once.

// File: rtl/can_rx_filter.sv
module can_rx_filter #(
  parameter int NMB  = 8,
  parameter int IDW  = 29,
  parameter int SIDW = 11,
  parameter int MBW  = $clog2(NMB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [MBW-1:0]  cfg_mb,
  input  logic [2:0]      cfg_sel,
  input  logic [31:0]     cfg_wdata,
  input  logic            cmd_arm,
  input  logic [MBW-1:0]  cmd_mb,
  input  logic [MBW-1:0]  rd_mb,
  input  logic [2:0]      rd_sel,
  output logic [31:0]     rd_data,
  input  logic            rx_valid,
  input  logic [IDW-1:0]  rx_id,
  input  logic            rx_ext,
  input  logic [3:0]      rx_dlc,
  input  logic [63:0]     rx_data,
  output logic            hit,
  output logic [MBW-1:0]  hit_mb
);

  localparam logic [IDW-1:0] STDM = {{SIDW{1'b1}}, {(IDW-SIDW){1'b0}}};

  logic [2:0]     mode [NMB];
  logic [IDW:0]   mask [NMB];
  logic [IDW:0]   idr  [NMB];
  logic [3:0]     dlc  [NMB];
  logic [31:0]    dlo  [NMB];
  logic [31:0]    dhi  [NMB];
  logic [IDW-1:0] fam  [NMB];
  logic [NMB-1:0] rdy, ign;

  logic [NMB-1:0] is_rx, want_ext, match, free;
  logic [IDW-1:0] cmpm [NMB];

  for (genvar i = 0; i < NMB; i++) begin : g_cmp
    assign is_rx[i]    = (mode[i] == 3'd1) || (mode[i] == 3'd2);
    assign want_ext[i] = mask[i][IDW] & idr[i][IDW];
    assign cmpm[i]     = want_ext[i] ? mask[i][IDW-1:0] : (mask[i][IDW-1:0] & STDM);
    assign match[i]    = rx_valid && is_rx[i] && (want_ext[i] == rx_ext) &&
                         ((rx_id & cmpm[i]) == (idr[i][IDW-1:0] & cmpm[i]));
  end
  assign free = match & ~rdy;

  logic           sel_any;
  logic [MBW-1:0] sel_idx;
  always_comb begin
    sel_any = |match;
    sel_idx = '0;
    for (int i = NMB-1; i >= 0; i--) if (match[i]) sel_idx = MBW'(i);
    if (|free)
      for (int i = NMB-1; i >= 0; i--) if (free[i]) sel_idx = MBW'(i);
  end

  logic [IDW-1:0] famv;
  assign famv = rx_id & ~mask[sel_idx][IDW-1:0] & (want_ext[sel_idx] ? {IDW{1'b1}} : STDM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit    <= 1'b0;
      hit_mb <= '0;
      rdy    <= '0;
      ign    <= '0;
      for (int i = 0; i < NMB; i++) begin
        mode[i] <= '0; mask[i] <= '0; idr[i] <= '0; dlc[i] <= '0;
        dlo[i]  <= '0; dhi[i]  <= '0; fam[i] <= '0;
      end
    end else begin
      hit    <= sel_any;
      hit_mb <= sel_idx;
      for (int i = 0; i < NMB; i++) begin
        if (cfg_we && cfg_mb == MBW'(i)) begin
          case (cfg_sel)
            3'd0: begin
              mode[i] <= cfg_wdata[2:0];
              if (cfg_wdata[2:0] == 3'd0) begin
                mask[i] <= '0; idr[i] <= '0; dlc[i] <= '0; dlo[i] <= '0;
                dhi[i]  <= '0; fam[i] <= '0; rdy[i] <= 1'b0; ign[i] <= 1'b0;
              end
            end
            3'd1: mask[i] <= cfg_wdata[IDW:0];
            3'd2: idr[i]  <= cfg_wdata[IDW:0];
            default: ;
          endcase
        end
        if (cmd_arm && cmd_mb == MBW'(i) && is_rx[i]) begin
          rdy[i] <= 1'b0;
          ign[i] <= 1'b0;
        end
        if (sel_any && sel_idx == MBW'(i)) begin
          if (rdy[i]) ign[i] <= 1'b1;
          else        rdy[i] <= 1'b1;
          if (!rdy[i] || mode[i] == 3'd2) begin
            dlc[i] <= rx_dlc;
            dlo[i] <= rx_data[31:0];
            dhi[i] <= (rx_dlc > 4'd4) ? rx_data[63:32] : 32'd0;
            fam[i] <= famv;
          end
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = 32'(mode[rd_mb]);
      3'd1:    rd_data = 32'(mask[rd_mb]);
      3'd2:    rd_data = 32'(idr[rd_mb]);
      3'd3:    rd_data = {24'd0, dlc[rd_mb], 2'b00, ign[rd_mb], rdy[rd_mb]};
      3'd4:    rd_data = dlo[rd_mb];
      3'd5:    rd_data = dhi[rd_mb];
      3'd6:    rd_data = 32'(fam[rd_mb]);
      default: rd_data = 32'd0;
    endcase
  end

  for (genvar i = 0; i < NMB; i++) begin : g_chk
    assert_ready_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy[i]) |-> $past(rx_valid) && $past(is_rx[i]));
    assert_ignore_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ign[i]) |-> $past(rdy[i]));
    assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_arm && cmd_mb == MBW'(i) && is_rx[i] && !match[i]) |=> !rdy[i] && !ign[i]);
  end

  assert_hit_target_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> rdy[hit_mb]);
  assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rdy & ~$past(rdy)) <= 1);

endmodule

// File: tb/test_can_rx_filter.sv
module test_can_rx_filter;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cmd_arm = 0, rx_valid = 0, rx_ext = 0;
  logic [2:0]  cfg_mb = 0, cfg_sel = 0, cmd_mb = 0, rd_mb = 0, rd_sel = 0;
  logic [31:0] cfg_wdata = 0, rd_data;
  logic [28:0] rx_id = 0;
  logic [3:0]  rx_dlc = 0;
  logic [63:0] rx_data = 0;
  logic        hit;
  logic [2:0]  hit_mb;

  always #10 clk = ~clk;

  can_rx_filter i_can_rx_filter (.*);

  localparam logic [28:0] STD = 29'h1FFC0000;
  int total = 0, bad = 0;
  logic [2:0]  m_mode [8];
  logic [29:0] m_mask [8], m_id [8];
  logic        m_rdy [8], m_ign [8];
  logic [3:0]  m_dlc [8];
  logic [31:0] m_lo [8], m_hi [8];
  logic [28:0] m_fam [8];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int mb, input int sel, output logic [31:0] v);
    rd_mb = 3'(mb); rd_sel = 3'(sel); #1; v = rd_data;
  endtask

  function automatic logic [28:0] cm(int i);
    logic we = m_mask[i][29] & m_id[i][29];
    return we ? m_mask[i][28:0] : (m_mask[i][28:0] & STD);
  endfunction

  task automatic check_all(string tag);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(i, 3, v); chk({tag, " status R7 R8 R10"}, v, {24'd0, m_dlc[i], 2'b00, m_ign[i], m_rdy[i]});
      rd(i, 4, v); chk({tag, " low R7 R9"}, v, m_lo[i]);
      rd(i, 5, v); chk({tag, " high R7"}, v, m_hi[i]);
      rd(i, 6, v); chk({tag, " family R11"}, v, 32'(m_fam[i]));
    end
  endtask

  task automatic cfg(int mb, int sel, logic [31:0] d);
    cfg_we = 1; cfg_mb = 3'(mb); cfg_sel = 3'(sel); cfg_wdata = d;
    @(posedge clk); @(negedge clk); cfg_we = 0;
    if (sel == 0) begin
      m_mode[mb] = d[2:0];
      if (d[2:0] == 0) begin
        m_mask[mb] = 0; m_id[mb] = 0; m_rdy[mb] = 0; m_ign[mb] = 0;
        m_dlc[mb] = 0; m_lo[mb] = 0; m_hi[mb] = 0; m_fam[mb] = 0;
      end
    end else if (sel == 1) m_mask[mb] = d[29:0];
    else if (sel == 2) m_id[mb] = d[29:0];
  endtask

  task automatic arm(int mb);
    cmd_arm = 1; cmd_mb = 3'(mb);
    @(posedge clk); @(negedge clk); cmd_arm = 0;
    if (m_mode[mb] == 1 || m_mode[mb] == 2) begin m_rdy[mb] = 0; m_ign[mb] = 0; end
  endtask

  task automatic frame(string tag, logic [28:0] id, logic ext, logic [3:0] dl, logic [63:0] d);
    int first = -1, freew = -1, w;
    for (int i = 7; i >= 0; i--) begin
      logic we = m_mask[i][29] & m_id[i][29];
      if ((m_mode[i] == 1 || m_mode[i] == 2) && we == ext && ((id & cm(i)) == (m_id[i][28:0] & cm(i)))) begin
        first = i;
        if (!m_rdy[i]) freew = i;
      end
    end
    w = (freew >= 0) ? freew : first;
    rx_valid = 1; rx_id = id; rx_ext = ext; rx_dlc = dl; rx_data = d;
    @(posedge clk); @(negedge clk); rx_valid = 0;
    chk({tag, " hit R12"}, 32'(hit), 32'(w >= 0));
    if (w >= 0) begin
      chk({tag, " winner R6"}, 32'(hit_mb), 32'(w));
      if (m_rdy[w]) m_ign[w] = 1;
      if (!m_rdy[w] || m_mode[w] == 2) begin
        m_dlc[w] = dl; m_lo[w] = d[31:0]; m_hi[w] = (dl > 4) ? d[63:32] : 0;
        m_fam[w] = id & ~m_mask[w][28:0] & ((m_mask[w][29] & m_id[w][29]) ? 29'h1FFFFFFF : STD);
      end
      m_rdy[w] = 1;
    end
    check_all(tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin
      m_mode[i] = 0; m_mask[i] = 0; m_id[i] = 0; m_rdy[i] = 0; m_ign[i] = 0;
      m_dlc[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_fam[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset hit R1", 32'(hit), 0);
    for (int i = 0; i < 8; i++)
      for (int s = 0; s < 7; s++) begin rd(i, s, v); chk("reset field R1", v, 0); end

    // R3 R6: three standard mailboxes sharing one ID, mailbox 1 normal, 2 overwrite, 5 normal
    foreach (m_mode[i]) if (i == 1 || i == 2 || i == 5) begin
      cfg(i, 1, 32'h1FFC0000); cfg(i, 2, 32'h123 << 18); cfg(i, 0, (i == 2) ? 2 : 1);
    end
    frame("std first R3", 29'h123 << 18 | 29'h5, 0, 4'd3, 64'hAAAA_BBBB_1122_3344);
    frame("std second R6", 29'h123 << 18, 0, 4'd8, 64'h5566_7788_99AA_BBCC);
    frame("std third R6", 29'h123 << 18, 0, 4'd5, 64'h0102_0304_0506_0708);
    frame("all ready normal R8", 29'h123 << 18, 0, 4'd2, 64'hDEAD_BEEF_CAFE_F00D);
    frame("mismatch R3", 29'h124 << 18, 0, 4'd1, 64'h1);
    arm(1);
    check_all("arm R10");
    // R9: only the overwrite mailbox matches this ID
    cfg(2, 2, 32'h0AA << 18); frame("ow fill R9", 29'h0AA << 18, 0, 4'd1, 64'h11);
    frame("ow replace R9", 29'h0AA << 18, 0, 4'd7, 64'h9876_5432_1000_0001);
    // R4: extended mailbox; standard frame of same bits must miss
    cfg(3, 1, 32'h2000_00F0); cfg(3, 2, 32'h2000_0050); cfg(3, 0, 1);
    frame("std to ext R4", 29'h50, 0, 4'd1, 64'h2);
    frame("ext hit R4 R11", 29'h1ABC_DE5F, 1, 4'd4, 64'hFFFF_FFFF_0000_0042);
    cfg(4, 1, 32'h2000_0000); cfg(4, 2, 32'h0000_0000); cfg(4, 0, 1);
    frame("one ext bit R4", 29'h7, 1, 4'd1, 64'h3);
    // R5: modes 3 and 7 never accept
    cfg(6, 1, 0); cfg(6, 0, 3); cfg(7, 1, 0); cfg(7, 0, 7);
    frame("mode ignored R5", 29'h3FF << 18, 0, 4'd1, 64'h4);
    // R2: clearing a filled mailbox
    cfg(5, 0, 0);
    for (int s = 0; s < 7; s++) begin rd(5, s, v); chk("mode0 clear R2", v, 0); end

    for (int n = 0; n < 400; n++) begin
      int mb = int'($urandom_range(7));
      case ($urandom_range(5))
        0: begin
          logic [29:0] mk = {1'($urandom), 29'($urandom & $urandom & $urandom)};
          cfg(mb, 1, 32'(mk));
          cfg(mb, 2, {2'b0, 1'($urandom), 29'($urandom)});
          cfg(mb, 0, 32'($urandom_range(3)));
        end
        1: arm(mb);
        default: begin
          logic [28:0] id = m_id[mb][28:0] ^ (29'($urandom) & ~cm(mb));
          logic ex = (m_mask[mb][29] & m_id[mb][29]) ^ ($urandom_range(9) == 0);
          frame("random R6 R7 R8 R9", id, ex, 4'($urandom_range(8)), {$urandom, $urandom});
        end
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule